// File: doc/BRIEF.md
# Read/Write Command Queue Selection Arbiter

This block decides, every clock cycle, which of the pending command queues sends its head command next: the read queue or the write queue. When a split-read mode is on, reads arrive in two queues, an urgent one and a normal one. Each head command carries a priority class, and class 0 marks it as urgent. The choice depends on four things: whether a head is class 0, whether its type matches the type issued last, how long each head has waited, and whether a head has waited so long that it must be served.

The block keeps a waiting-age counter for each queue and remembers the type of the last command it issued. The selected command leaves in the same cycle it is presented: the grant is a combinational function of the head inputs and the registered state. The queue that receives a grant pops its head at the next clock edge. The block stores no commands and does not schedule anything toward memory.

Top module: `rwq_select_arbiter`

## Requirements
- R1: After reset the last-issued type is read (`last_wr` = 0), every age is 0, and nothing is granted while no eligible queue is valid.
- R2: `grant` is one-hot or zero, with bit 0 for the normal read queue, bit 1 for the urgent read queue and bit 2 for the write queue. `issue_vld` is high exactly when at least one eligible queue is valid, so a cycle with work pending is never left idle. `issue_wr` equals `grant[2]`.
- R3: When the write head and the read candidate are both class 0 and neither has expired, the queue whose type matches `last_wr` wins.
- R4: When the older of the two heads is not class 0 and has not expired, and the other head is class 0, the other head wins.
- R5: When the older head is class 0 but of the opposite type to `last_wr`, it wins if the other head is not class 0.
- R6: When neither valid head is class 0 and neither has expired, the queue of the last-issued type wins if it is valid. Otherwise the other valid queue wins.
- R7: The write head is older when its age exceeds the age of the read candidate. On equal ages, the head of the last-issued type counts as older.
- R8: A queue's age rises by one per cycle, saturating at 2^AGE_W-1, while its head is valid, eligible and not granted. It returns to 0 when the queue is granted or has no valid head. An older head whose age has reached the saturation value wins regardless of class.
- R9: With `split_en` = 0 the urgent read queue is ignored: it is never granted and it takes no part in the choice.
- R10: With `split_en` = 1 a valid urgent read head becomes the read candidate and is always served before the normal read queue. The rules R3 to R8 apply to it in place of the normal read head.
- R11: `last_wr` takes the value of `issue_wr` at every clock edge where `issue_vld` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| split_en | input | 1 | Enables the separate urgent read queue |
| lpr_vld | input | 1 | Normal read queue head valid |
| lpr_prio | input | PRIO_W | Normal read head priority class (0 = urgent) |
| hpr_vld | input | 1 | Urgent read queue head valid |
| hpr_prio | input | PRIO_W | Urgent read head priority class |
| wr_vld | input | 1 | Write queue head valid |
| wr_prio | input | PRIO_W | Write head priority class |
| grant | output | 3 | One-hot queue select: bit 0 normal read, bit 1 urgent read, bit 2 write |
| issue_vld | output | 1 | A command is issued this cycle |
| issue_wr | output | 1 | The issued command is a write |
| last_wr | output | 1 | Type of the last issued command (1 = write) |

## Verification
The bench targets the cases where the class-0 rules and the last-type memory interact. One case has both heads urgent while the older head is of the opposite type; a design that simply trusted age would flip direction there. Another case has only the older head urgent, where the direction must change; a design that was sticky in every case would hold it. A directed starvation run holds a non-urgent write behind a stream of urgent reads and expects the write to win in exactly the cycle its age saturates; a counter that wraps, or that fails to clear, misses that cycle. The split-mode cases check that a masked urgent read head is never granted and that an enabled one always pre-empts the normal read queue.

// File: rtl/rwq_arb_pkg.sv
package rwq_arb_pkg;

  typedef enum logic {
    CMD_RD = 1'b0,
    CMD_WR = 1'b1
  } cmd_kind_e;

  // Saturating increment of a waiting age.
  function automatic int unsigned age_step(int unsigned cur, int unsigned top);
    return (cur >= top) ? top : cur + 1;
  endfunction

  // Age ordering between the read candidate and the write head; a tie is
  // resolved toward the type issued last.
  function automatic logic write_is_older(int unsigned rd_age, int unsigned wr_age,
                                          logic last_was_wr);
    return (wr_age > rd_age) || ((wr_age == rd_age) && last_was_wr);
  endfunction

endpackage

// File: rtl/rwq_age_ctr.sv
module rwq_age_ctr #(
  parameter int AGE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             waiting,
  output logic [AGE_W-1:0] age,
  output logic             expired
);
  import rwq_arb_pkg::*;

  localparam int unsigned AGE_MAX = (1 << AGE_W) - 1;

  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        age_q <= '0;
    else if (waiting)  age_q <= AGE_W'(age_step(32'(age_q), AGE_MAX));
    else               age_q <= '0;
  end

  assign age     = age_q;
  assign expired = (32'(age_q) == AGE_MAX);

endmodule

// File: rtl/rwq_pick.sv
module rwq_pick #(
  parameter int PRIO_W = 2,
  parameter int AGE_W  = 4
) (
  input  logic [2:0]        elig,       // {wr, urgent rd (masked), normal rd}
  input  logic [PRIO_W-1:0] lpr_prio,
  input  logic [PRIO_W-1:0] hpr_prio,
  input  logic [PRIO_W-1:0] wr_prio,
  input  logic [AGE_W-1:0]  age_lpr,
  input  logic [AGE_W-1:0]  age_hpr,
  input  logic [AGE_W-1:0]  age_wr,
  input  logic [2:0]        exp_flags,
  input  logic              last_wr,
  output logic [2:0]        grant,
  output logic              issue_vld,
  output logic              issue_wr,
  output logic              rd_cand_exp
);
  import rwq_arb_pkg::*;

  // Read candidate: urgent read queue when present, else the normal one.
  logic             use_hpr, rd_v, wr_v, rd_p0, wr_p0;
  logic [AGE_W-1:0] rd_age;

  assign use_hpr     = elig[1];
  assign rd_v        = elig[1] | elig[0];
  assign wr_v        = elig[2];
  assign rd_p0       = use_hpr ? (hpr_prio == '0) : (lpr_prio == '0);
  assign wr_p0       = (wr_prio == '0);
  assign rd_age      = use_hpr ? age_hpr : age_lpr;
  assign rd_cand_exp = use_hpr ? exp_flags[1] : exp_flags[0];

  // First candidate is the older head.
  logic first_wr, f_p0, f_exp, o_v, o_p0, last_v;

  always_comb begin
    if (!rd_v)       first_wr = 1'b1;
    else if (!wr_v)  first_wr = 1'b0;
    else             first_wr = write_is_older(32'(rd_age), 32'(age_wr), last_wr);
  end

  assign f_p0   = first_wr ? wr_p0 : rd_p0;
  assign f_exp  = first_wr ? exp_flags[2] : rd_cand_exp;
  assign o_v    = first_wr ? rd_v : wr_v;
  assign o_p0   = first_wr ? rd_p0 : wr_p0;
  assign last_v = last_wr ? wr_v : rd_v;

  logic win_wr;

  always_comb begin
    if (f_exp)                          win_wr = first_wr;
    else if (f_p0 && first_wr == last_wr) win_wr = first_wr;
    else if (o_v && o_p0)               win_wr = ~first_wr;
    else if (f_p0)                      win_wr = first_wr;
    else if (last_v)                    win_wr = last_wr;
    else                                win_wr = ~last_wr;
  end

  assign issue_vld = rd_v | wr_v;
  assign issue_wr  = issue_vld & win_wr;

  always_comb begin
    if (!issue_vld)   grant = 3'b000;
    else if (win_wr)  grant = 3'b100;
    else if (use_hpr) grant = 3'b010;
    else              grant = 3'b001;
  end

endmodule

// File: rtl/rwq_last_type.sv
module rwq_last_type (
  input  logic clk,
  input  logic rst_n,
  input  logic issue_vld,
  input  logic issue_wr,
  output logic last_wr
);
  import rwq_arb_pkg::*;

  cmd_kind_e last_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         last_q <= CMD_RD;
    else if (issue_vld) last_q <= issue_wr ? CMD_WR : CMD_RD;
  end

  assign last_wr = (last_q == CMD_WR);

endmodule

// File: rtl/rwq_select_arbiter.sv
module rwq_select_arbiter #(
  parameter int PRIO_W = 2,
  parameter int AGE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              split_en,
  input  logic              lpr_vld,
  input  logic [PRIO_W-1:0] lpr_prio,
  input  logic              hpr_vld,
  input  logic [PRIO_W-1:0] hpr_prio,
  input  logic              wr_vld,
  input  logic [PRIO_W-1:0] wr_prio,
  output logic [2:0]        grant,
  output logic              issue_vld,
  output logic              issue_wr,
  output logic              last_wr
);
  localparam int NQ = 3;

  logic [NQ-1:0]    elig;
  logic [NQ-1:0]    exp_q;
  logic [AGE_W-1:0] age_q [NQ];
  logic             rd_cand_exp;
  logic             wr_age_exp;

  assign elig       = {wr_vld, split_en & hpr_vld, lpr_vld};
  assign wr_age_exp = exp_q[2];

  for (genvar q = 0; q < NQ; q++) begin : g_age
    rwq_age_ctr #(.AGE_W(AGE_W)) u_age (
      .clk     (clk),
      .rst_n   (rst_n),
      .waiting (elig[q] & ~grant[q]),
      .age     (age_q[q]),
      .expired (exp_q[q])
    );
  end

  rwq_pick #(.PRIO_W(PRIO_W), .AGE_W(AGE_W)) u_pick (
    .elig        (elig),
    .lpr_prio    (lpr_prio),
    .hpr_prio    (hpr_prio),
    .wr_prio     (wr_prio),
    .age_lpr     (age_q[0]),
    .age_hpr     (age_q[1]),
    .age_wr      (age_q[2]),
    .exp_flags   (exp_q),
    .last_wr     (last_wr),
    .grant       (grant),
    .issue_vld   (issue_vld),
    .issue_wr    (issue_wr),
    .rd_cand_exp (rd_cand_exp)
  );

  rwq_last_type u_last (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue_vld (issue_vld),
    .issue_wr  (issue_wr),
    .last_wr   (last_wr)
  );

endmodule

// File: rtl/rwq_select_arbiter_chk.sv
module rwq_select_arbiter_chk #(
  parameter int PRIO_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              split_en,
  input logic              lpr_vld,
  input logic [PRIO_W-1:0] lpr_prio,
  input logic              hpr_vld,
  input logic [PRIO_W-1:0] hpr_prio,
  input logic              wr_vld,
  input logic [PRIO_W-1:0] wr_prio,
  input logic [2:0]        grant,
  input logic              issue_vld,
  input logic              issue_wr,
  input logic              last_wr,
  input logic              rd_exp,
  input logic              wr_exp
);
  logic any_elig, hpr_on, rd_v, rd_p0;

  assign hpr_on   = split_en & hpr_vld;
  assign rd_v     = hpr_on | lpr_vld;
  assign rd_p0    = hpr_on ? (hpr_prio == '0) : (lpr_prio == '0);
  assign any_elig = rd_v | wr_vld;

  a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r2_no_idle: assert property (@(posedge clk) disable iff (!rst_n)
    any_elig |-> (issue_vld && $countones(grant) == 1));

  a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !any_elig |-> (!issue_vld && grant == 3'b000));

  a_r9_hpr_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !split_en |-> !grant[1]);

  a_r10_hpr_before_lpr: assert property (@(posedge clk) disable iff (!rst_n)
    hpr_on |-> !grant[0]);

  a_r5_lone_urgent_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && wr_prio == '0 && rd_v && !rd_p0 && !rd_exp) |-> grant[2]);

  a_r6_sticky_type: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && rd_v && wr_prio != '0 && !rd_p0 && !rd_exp && !wr_exp)
      |-> (issue_wr == last_wr));

  a_r8_expired_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && wr_exp && rd_v && !rd_exp) |-> grant[2]);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_vld |=> $stable(last_wr));

  a_r11_update: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |=> (last_wr == $past(issue_wr)));

endmodule

bind rwq_select_arbiter rwq_select_arbiter_chk #(.PRIO_W(PRIO_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .split_en  (split_en),
  .lpr_vld   (lpr_vld),
  .lpr_prio  (lpr_prio),
  .hpr_vld   (hpr_vld),
  .hpr_prio  (hpr_prio),
  .wr_vld    (wr_vld),
  .wr_prio   (wr_prio),
  .grant     (grant),
  .issue_vld (issue_vld),
  .issue_wr  (issue_wr),
  .last_wr   (last_wr),
  .rd_exp    (rd_cand_exp),
  .wr_exp    (wr_age_exp)
);

// File: tb/test_rwq_select_arbiter.sv
module test_rwq_select_arbiter;
  localparam int PRIO_W = 2;
  localparam int AGE_W  = 4;
  localparam int AMAX   = (1 << AGE_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              split_en = 1'b0;
  logic              lpr_vld = 1'b0, hpr_vld = 1'b0, wr_vld = 1'b0;
  logic [PRIO_W-1:0] lpr_prio = '0, hpr_prio = '0, wr_prio = '0;
  logic [2:0]        grant;
  logic              issue_vld, issue_wr, last_wr;

  int n_chk = 0;
  int n_bad = 0;

  // bench model state
  int m_la = 0, m_ha = 0, m_wa = 0;
  bit m_last = 1'b0;

  always #4 clk = ~clk;

  rwq_select_arbiter #(.PRIO_W(PRIO_W), .AGE_W(AGE_W)) i_rwq_select_arbiter (
    .clk(clk), .rst_n(rst_n), .split_en(split_en),
    .lpr_vld(lpr_vld), .lpr_prio(lpr_prio),
    .hpr_vld(hpr_vld), .hpr_prio(hpr_prio),
    .wr_vld(wr_vld), .wr_prio(wr_prio),
    .grant(grant), .issue_vld(issue_vld), .issue_wr(issue_wr), .last_wr(last_wr)
  );

  function automatic logic [2:0] model_pick(bit sp, bit lv, int lp, bit hv, int hp,
                                            bit wv, int wp, int la, int ha, int wa, bit lw);
    bit hv_e, rv, wr_first, wr_win;
    int rp, ra, fa, fp, op;
    logic [2:0] rg;
    hv_e = sp && hv;
    rv   = hv_e || lv;
    rp   = hv_e ? hp : lp;
    ra   = hv_e ? ha : la;
    rg   = hv_e ? 3'b010 : 3'b001;
    if (!rv && !wv) return 3'b000;
    if (!rv) return 3'b100;
    if (!wv) return rg;
    wr_first = (wa > ra) || (wa == ra && lw);
    fa = wr_first ? wa : ra;
    fp = wr_first ? wp : rp;
    op = wr_first ? rp : wp;
    if (fa == AMAX)              wr_win = wr_first;
    else if (fp == 0 && op == 0) wr_win = lw;
    else if (fp == 0)            wr_win = wr_first;
    else if (op == 0)            wr_win = !wr_first;
    else                         wr_win = lw;
    return wr_win ? 3'b100 : rg;
  endfunction

  function automatic int next_age(bit waiting, int cur);
    if (!waiting) return 0;
    return (cur >= AMAX) ? AMAX : cur + 1;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // One cycle: drive at negedge, sample mid-low phase, advance the model.
  task automatic cyc(input bit sp, input bit lv, input int lp, input bit hv, input int hp,
                     input bit wv, input int wp, input int exp_g, input string req);
    logic [2:0] mg, eg;
    logic [5:0] got, want;
    @(negedge clk);
    split_en = sp; lpr_vld = lv; lpr_prio = PRIO_W'(lp);
    hpr_vld = hv; hpr_prio = PRIO_W'(hp); wr_vld = wv; wr_prio = PRIO_W'(wp);
    #2;
    mg = model_pick(sp, lv, lp, hv, hp, wv, wp, m_la, m_ha, m_wa, m_last);
    eg = (exp_g < 0) ? mg : exp_g[2:0];
    want = {eg, |eg, eg[2], m_last};
    got  = {grant, issue_vld, issue_wr, last_wr};
    n_chk++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s: {grant,vld,wr,last} actual=%b expected=%b", req, got, want);
    end
    m_la = next_age(lv && !mg[0], m_la);
    m_ha = next_age(sp && hv && !mg[1], m_ha);
    m_wa = next_age(wv && !mg[2], m_wa);
    if (|mg) m_last = mg[2];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; split_en = 0; lpr_vld = 0; hpr_vld = 0; wr_vld = 0;
    lpr_prio = '0; hpr_prio = '0; wr_prio = '0;
    repeat (3) @(negedge clk);
    #2;
    n_chk++;
    if ({grant, issue_vld, last_wr} !== 5'b0) begin
      n_bad++;
      $display("FAIL R1: in reset actual=%b expected=00000", {grant, issue_vld, last_wr});
    end
    @(negedge clk);
    rst_n = 1'b1;
    m_la = 0; m_ha = 0; m_wa = 0; m_last = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL R2: watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    // R1: idle after reset, last type read
    cyc(0, 0, 0, 0, 0, 0, 0, 3'b000, "R1");
    // R1/R7/R6: equal ages, no class 0, last read -> normal read
    cyc(0, 1, 1, 0, 0, 1, 1, 3'b001, "R7");
    // R3: both class 0, write older but last type read -> read
    cyc(0, 1, 0, 0, 0, 1, 0, 3'b001, "R3");
    // R5: older write class 0, opposite type, read not class 0 -> write
    cyc(0, 1, 1, 0, 0, 1, 0, 3'b100, "R5");
    // R4: older read not class 0, write class 0 -> write
    cyc(0, 1, 2, 0, 0, 1, 0, 3'b100, "R4");
    // R6: no class 0, last write -> write despite older read
    cyc(0, 1, 1, 0, 0, 1, 3, 3'b100, "R6");
    // R6: last-type queue empty -> the other queue
    cyc(0, 1, 1, 0, 0, 0, 0, 3'b001, "R6");
    // R9: urgent read head ignored while split mode is off
    cyc(0, 0, 0, 1, 0, 0, 0, 3'b000, "R9");
    cyc(0, 1, 2, 1, 0, 0, 0, 3'b001, "R9");
    // R10: urgent read head pre-empts the normal read queue
    cyc(1, 1, 0, 1, 3, 0, 0, 3'b010, "R10");
    cyc(1, 1, 0, 1, 0, 1, 0, -1, "R10");

    // R8: write waits behind urgent reads until its age saturates
    do_reset();
    for (int k = 0; k < AMAX; k++) cyc(0, 1, 0, 0, 0, 1, 1, 3'b001, "R8");
    cyc(0, 1, 0, 0, 0, 1, 1, 3'b100, "R8");
    cyc(0, 1, 0, 0, 0, 1, 1, -1, "R11");

    // R3/R4/R5/R6/R7/R8/R10/R11: random traffic against the model
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      bit sp;
      sp = ((n / 250) % 2) == 1;
      cyc(sp, ($urandom % 4) != 0, int'($urandom % 4), ($urandom % 3) == 0,
          int'($urandom % 4), ($urandom % 4) != 0, int'($urandom % 4), -1,
          "R3/R4/R5/R6/R7/R8/R10/R11");
    end

    summary();
    $finish;
  end

endmodule